// File: doc/BRIEF.md
# Tagged Reservation-Station Front-End for a Shared Function Unit

This block places a row of reservation-station slots in front of one shared integer function unit. Each slot takes a complete operand pair and an operation code in one clock through a strobe/acknowledge handshake. It keeps those values until the issue logic sends them to the function unit. Every operation that enters the unit carries a tag equal to the index of the slot that sent it. The tag and the operation code pass through every stage unchanged. When a result leaves the unit, its tag selects the slot whose result latch receives it. The slot then offers the result on its own output handshake.

The function unit has two paths. The main path is a fixed-length pipeline. The early-exit path handles operations with a zero operand and finishes after one stage. Results are steered by tag, not by arrival order, so the front-end works whatever the latency of each operation. An early-exit result and a main-path result issued earlier can finish in the same clock. For that reason every result latch can be written by either path, and two different slots can be written in the same cycle.

Top module: `rs_array_fe`

## Requirements
- R1: A free slot holds `in_ack` high. In the clock where `in_stb` and `in_ack` of a slot are both high, A, B and the operation code of that slot are all captured on the same edge.
- R2: At most one slot is issued per clock. Among the slots that hold operands not yet issued, the slot with the lowest index is issued first.
- R3: The operation code is two bits: 0 = A+B, 1 = A-B, 2 = A AND B, 3 = A OR B. The result is taken modulo 2^DW.
- R4: An operation with both operands nonzero takes the main path. If it is issued without waiting, its `out_stb` first reads high MAIN_LAT+2 edges after the capture edge, counting the capture edge (6 with defaults).
- R5: An operation with A = 0 or B = 0 takes the early-exit path. If it is issued without waiting, its `out_stb` first reads high 3 edges after the capture edge, counting the capture edge.
- R6: Each result is written only into the slot whose tag it carries, even when results come back in a different order from issue.
- R7: A main-path result and an early-exit result for two different slots can finish on the same clock, and both are stored. A same-slot double completion cannot occur.
- R8: From capture until its result is acknowledged, a slot holds `in_ack` low and ignores `in_stb`. While `out_stb` is high and `out_ack` is low, `out_stb` stays high and `out_z` does not change. The handshake with `out_ack` high frees the slot on the next edge.
- R9: After synchronous active-low reset, every `in_ack` is high and every `out_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_stb | input | NSLOT | Per-slot operand strobe |
| in_ack | output | NSLOT | Per-slot operand acknowledge (slot free) |
| in_a | input | NSLOT*DW | Operand A, slot s at bits [s*DW +: DW] |
| in_b | input | NSLOT*DW | Operand B, slot s at bits [s*DW +: DW] |
| in_op | input | NSLOT*2 | Operation code, slot s at bits [s*2 +: 2] |
| out_stb | output | NSLOT | Per-slot result strobe |
| out_ack | input | NSLOT | Per-slot result acknowledge |
| out_z | output | NSLOT*DW | Result, slot s at bits [s*DW +: DW] |

## Verification
The assertions check these rules on every cycle:
- the issue grant is one-hot or idle, and it only goes to a slot that is asking for issue;
- every completion lands on a slot that is waiting for a result;
- the two paths never complete into the same slot in the same cycle;
- an operand pair with a zero operand enters the early-exit path with its tag intact;
- a pending output holds steady until it is acknowledged.

Some behaviour only the directed scenarios can show. These are the exact arithmetic values, the latency of each path, lowest-index issue order when several slots load together, out-of-order return, and the timing of a real same-cycle dual completion.

// File: rtl/rsfe_pkg.sv
// Shared types for the reservation-station front-end.
// Assumes: the operation code is two bits wide in every variant.
package rsfe_pkg;

    // Operation codes understood by the shared function unit
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_OR  = 2'd3
    } fu_op_e;

    // Life cycle of one reservation-station slot
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,   // waiting for operands
        ST_PEND = 2'd1,   // operands held, not yet issued
        ST_BUSY = 2'd2,   // issued, result latch reserved
        ST_DONE = 2'd3    // result held, offered at output
    } slot_st_e;

endpackage

// File: rtl/rsfe_slot.sv
// One reservation-station slot.
// Captures an operand pair in a single clock and asks for issue.
// It then waits, for any latency, for a result on either of two write ports,
// and offers the result until it is acknowledged.
// Assumes: the write ports are only driven for this slot's tag while it is BUSY.
module rsfe_slot
    import rsfe_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_stb,
    output logic          in_ack,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  fu_op_e        in_op,
    output logic          iss_req,
    input  logic          iss_gnt,
    output logic [DW-1:0] hold_a,
    output logic [DW-1:0] hold_b,
    output fu_op_e        hold_op,
    output logic          busy,
    input  logic          wr_main,
    input  logic [DW-1:0] wr_main_z,
    input  logic          wr_early,
    input  logic [DW-1:0] wr_early_z,
    output logic          out_stb,
    input  logic          out_ack,
    output logic [DW-1:0] out_z
);

    slot_st_e      st;
    logic [DW-1:0] z_q;

    assign in_ack  = (st == ST_FREE);
    assign iss_req = (st == ST_PEND);
    assign busy    = (st == ST_BUSY);
    assign out_stb = (st == ST_DONE);
    assign out_z   = z_q;

    // State sequencing and operand/result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_FREE;
            hold_a  <= '0;
            hold_b  <= '0;
            hold_op <= OP_ADD;
            z_q     <= '0;
        end else begin
            unique case (st)
                ST_FREE: if (in_stb) begin
                    hold_a  <= in_a;
                    hold_b  <= in_b;
                    hold_op <= in_op;
                    st      <= ST_PEND;
                end
                ST_PEND: if (iss_gnt) st <= ST_BUSY;
                ST_BUSY: begin
                    if (wr_main) begin
                        z_q <= wr_main_z;
                        st  <= ST_DONE;
                    end else if (wr_early) begin
                        z_q <= wr_early_z;
                        st  <= ST_DONE;
                    end
                end
                ST_DONE: if (out_ack) st <= ST_FREE;
                default: st <= ST_FREE;
            endcase
        end
    end

    // A completion may only hit a slot that reserved its latch (R6)
    assert_write_only_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_main || wr_early) |-> (st == ST_BUSY));

    // Both paths never finish into the same slot together (R7)
    assert_no_same_slot_dual_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_main && wr_early));

    // A pending result is held until acknowledged (R8)
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb && !out_ack) |=> (out_stb && $stable(out_z)));

    // An unacknowledged slot never reopens its input side (R8)
    assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb && !out_ack) |=> !in_ack);

endmodule

// File: rtl/rsfe_pick.sv
// Issue selector: grants the lowest-index requesting slot, at most one per clock.
// Assumes: NSLOT >= 1; purely combinational.
module rsfe_pick #(
    parameter int NSLOT = 4,
    parameter int TW    = 2
) (
    input  logic [NSLOT-1:0] req,
    output logic [NSLOT-1:0] gnt,
    output logic [TW-1:0]    gnt_idx,
    output logic             any
);

    // Scan from the top so that the lowest requester wins last
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt     = '0;
                gnt[i]  = 1'b1;
                gnt_idx = TW'(i);
                any     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rsfe_fu.sv
// Shared integer function unit model with two completion paths.
// Main path: MAIN_LAT register stages. Early-exit path: one register stage,
// taken when either operand is zero. The tag rides unchanged beside the data.
// Assumes: MAIN_LAT >= 2; the unit never stalls, so issue is always accepted.
module rsfe_fu
    import rsfe_pkg::*;
#(
    parameter int DW       = 16,
    parameter int TW       = 2,
    parameter int MAIN_LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_stb,
    output logic          iss_ack,
    input  logic [DW-1:0] iss_a,
    input  logic [DW-1:0] iss_b,
    input  fu_op_e        iss_op,
    input  logic [TW-1:0] iss_tag,
    output logic          m_vld,
    output logic [TW-1:0] m_tag,
    output logic [DW-1:0] m_z,
    output logic          e_vld,
    output logic [TW-1:0] e_tag,
    output logic [DW-1:0] e_z
);

    logic          special;
    logic [DW-1:0] calc;
    logic          pv [MAIN_LAT];
    logic [TW-1:0] pt [MAIN_LAT];
    logic [DW-1:0] pz [MAIN_LAT];

    assign iss_ack = 1'b1;
    assign special = (iss_a == '0) || (iss_b == '0);

    // Operation evaluation shared by both paths
    always_comb begin
        unique case (iss_op)
            OP_ADD:  calc = iss_a + iss_b;
            OP_SUB:  calc = iss_a - iss_b;
            OP_AND:  calc = iss_a & iss_b;
            OP_OR:   calc = iss_a | iss_b;
            default: calc = '0;
        endcase
    end

    // Main pipeline: stage 0 loads on issue, later stages shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MAIN_LAT; k++) begin
                pv[k] <= 1'b0;
                pt[k] <= '0;
                pz[k] <= '0;
            end
        end else begin
            pv[0] <= iss_stb && iss_ack && !special;
            pt[0] <= iss_tag;
            pz[0] <= calc;
            for (int k = 1; k < MAIN_LAT; k++) begin
                pv[k] <= pv[k-1];
                pt[k] <= pt[k-1];
                pz[k] <= pz[k-1];
            end
        end
    end

    // Early-exit register for zero-operand cases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld <= 1'b0;
            e_tag <= '0;
            e_z   <= '0;
        end else begin
            e_vld <= iss_stb && iss_ack && special;
            e_tag <= iss_tag;
            e_z   <= calc;
        end
    end

    assign m_vld = pv[MAIN_LAT-1];
    assign m_tag = pt[MAIN_LAT-1];
    assign m_z   = pz[MAIN_LAT-1];

    // A zero operand leaves by the early path next clock with its tag (R5)
    assert_early_exit_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_stb && special) |=> (e_vld && e_tag == $past(iss_tag)));

endmodule

// File: rtl/rs_array_fe.sv
// Top: NSLOT reservation-station slots sharing one function unit.
// Slots capture operand pairs, the picker issues one per clock, and results
// come back by tag through two write ports into per-slot result latches.
// Assumes: NSLOT >= 2, MAIN_LAT >= 2.
module rs_array_fe
    import rsfe_pkg::*;
#(
    parameter int NSLOT    = 4,
    parameter int DW       = 16,
    parameter int MAIN_LAT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSLOT-1:0]    in_stb,
    output logic [NSLOT-1:0]    in_ack,
    input  logic [NSLOT*DW-1:0] in_a,
    input  logic [NSLOT*DW-1:0] in_b,
    input  logic [NSLOT*2-1:0]  in_op,
    output logic [NSLOT-1:0]    out_stb,
    input  logic [NSLOT-1:0]    out_ack,
    output logic [NSLOT*DW-1:0] out_z
);

    localparam int TW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic [NSLOT-1:0] req, gnt, busy;
    logic [TW-1:0]    gnt_idx;
    logic             any_req, fu_ack;
    logic [DW-1:0]    sa [NSLOT];
    logic [DW-1:0]    sb [NSLOT];
    fu_op_e           sop [NSLOT];
    logic             m_vld, e_vld;
    logic [TW-1:0]    m_tag, e_tag;
    logic [DW-1:0]    m_z, e_z;

    // Per-slot storage with tag-decoded write enables
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [TW-1:0] MY_TAG = TW'(g);
        rsfe_slot #(.DW(DW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_stb     (in_stb[g]),
            .in_ack     (in_ack[g]),
            .in_a       (in_a[g*DW +: DW]),
            .in_b       (in_b[g*DW +: DW]),
            .in_op      (fu_op_e'(in_op[g*2 +: 2])),
            .iss_req    (req[g]),
            .iss_gnt    (gnt[g] && fu_ack),
            .hold_a     (sa[g]),
            .hold_b     (sb[g]),
            .hold_op    (sop[g]),
            .busy       (busy[g]),
            .wr_main    (m_vld && (m_tag == MY_TAG)),
            .wr_main_z  (m_z),
            .wr_early   (e_vld && (e_tag == MY_TAG)),
            .wr_early_z (e_z),
            .out_stb    (out_stb[g]),
            .out_ack    (out_ack[g]),
            .out_z      (out_z[g*DW +: DW])
        );
    end

    rsfe_pick #(.NSLOT(NSLOT), .TW(TW)) u_pick (
        .req     (req),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .any     (any_req)
    );

    rsfe_fu #(.DW(DW), .TW(TW), .MAIN_LAT(MAIN_LAT)) u_fu (
        .clk     (clk),
        .rst_n   (rst_n),
        .iss_stb (any_req),
        .iss_ack (fu_ack),
        .iss_a   (sa[gnt_idx]),
        .iss_b   (sb[gnt_idx]),
        .iss_op  (sop[gnt_idx]),
        .iss_tag (gnt_idx),
        .m_vld   (m_vld),
        .m_tag   (m_tag),
        .m_z     (m_z),
        .e_vld   (e_vld),
        .e_tag   (e_tag),
        .e_z     (e_z)
    );

    // Single issue per clock, only to a requesting slot (R2)
    assert_single_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~req) == '0));

    // Main-path result returns to a slot holding a reservation (R6)
    assert_main_tag_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_vld |-> busy[m_tag]);

    // Early-path result returns to a slot holding a reservation (R6)
    assert_early_tag_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        e_vld |-> busy[e_tag]);

    // Simultaneous completions always target different slots (R7)
    assert_dual_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_vld && e_vld) |-> (m_tag != e_tag));

endmodule

// File: tb/sim_rs_array_fe.sv
// Directed bench for rs_array_fe: one task per scenario, each self-checking.
module sim_rs_array_fe;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int DW = 16;
    localparam int ML = 4;
    localparam int MAIN_N  = ML + 2;
    localparam int EARLY_N = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      in_stb = '0;
    logic [N-1:0]      in_ack;
    logic [N*DW-1:0]   in_a = '0;
    logic [N*DW-1:0]   in_b = '0;
    logic [N*2-1:0]    in_op = '0;
    logic [N-1:0]      out_stb;
    logic [N-1:0]      out_ack = '0;
    logic [N*DW-1:0]   out_z;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_array_fe #(.NSLOT(N), .DW(DW), .MAIN_LAT(ML)) u0 (
        .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_ack(in_ack),
        .in_a(in_a), .in_b(in_b), .in_op(in_op),
        .out_stb(out_stb), .out_ack(out_ack), .out_z(out_z)
    );

    function automatic logic [DW-1:0] ref_z(logic [DW-1:0] a, logic [DW-1:0] b, int op);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            default: return a | b;
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] zof(int s);
        return out_z[s*DW +: DW];
    endfunction

    // Drive operands for one slot (call at a negedge)
    task automatic put(int s, logic [DW-1:0] a, logic [DW-1:0] b, int op);
        in_a[s*DW +: DW] = a;
        in_b[s*DW +: DW] = b;
        in_op[s*2 +: 2]  = 2'(op);
        in_stb[s] = 1'b1;
    endtask

    // Acknowledge a slot's result, then confirm it is freed
    task automatic take(int s, string req);
        out_ack[s] = 1'b1;
        @(negedge clk);
        out_ack[s] = 1'b0;
        chk(out_stb[s] == 1'b0, req, "out_stb after ack", out_stb[s], 0);
        chk(in_ack[s] == 1'b1, req, "in_ack after ack", in_ack[s], 1);
    endtask

    // Single operation on an idle unit: latency and value
    task automatic run_one(int s, logic [DW-1:0] a, logic [DW-1:0] b, int op,
                           int exp_n, string req);
        int n = 0;
        bit ack_low = 1'b1;
        put(s, a, b, op);
        do begin
            @(negedge clk);
            if (n == 0) in_stb[s] = 1'b0;
            n++;
            if (!out_stb[s] && in_ack[s]) ack_low = 1'b0;
        end while (!out_stb[s] && n < 30);
        chk(n == exp_n, req, "latency edges", n, exp_n);
        chk(zof(s) == ref_z(a, b, op), "R3", "result value", zof(s), ref_z(a, b, op));
        chk(ack_low, "R8", "in_ack low while reserved", ack_low, 1);
        take(s, "R8");
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(in_ack == '1, "R9", "in_ack after reset", in_ack, 4'hF);
        chk(out_stb == '0, "R9", "out_stb after reset", out_stb, 0);
    endtask

    task automatic t_main_ops;
        run_one(0, 16'd5, 16'd3, 0, MAIN_N, "R4");
        run_one(2, 16'd5, 16'd9, 1, MAIN_N, "R4");
        run_one(2, 16'hF0F0, 16'h3C3C, 2, MAIN_N, "R3");
        run_one(3, 16'hF000, 16'h000F, 3, MAIN_N, "R3");
        run_one(1, 16'hFFFF, 16'h0002, 0, MAIN_N, "R3");
    endtask

    task automatic t_early;
        run_one(1, 16'd0, 16'd7, 1, EARLY_N, "R5");
        run_one(3, 16'h1234, 16'd0, 3, EARLY_N, "R5");
    endtask

    // Slots 3,1,2 load together; issue must run 1,2,3
    task automatic t_priority;
        int seen [N];
        for (int s = 0; s < N; s++) seen[s] = 0;
        put(3, 16'd30, 16'd3, 0);
        put(1, 16'd10, 16'd1, 0);
        put(2, 16'd20, 16'd2, 1);
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            if (n == 1) in_stb = '0;
            for (int s = 0; s < N; s++) if (out_stb[s] && seen[s] == 0) seen[s] = n;
        end
        chk(seen[1] == MAIN_N,     "R2", "slot1 done edge", seen[1], MAIN_N);
        chk(seen[2] == MAIN_N + 1, "R2", "slot2 done edge", seen[2], MAIN_N + 1);
        chk(seen[3] == MAIN_N + 2, "R2", "slot3 done edge", seen[3], MAIN_N + 2);
        chk(zof(1) == 16'd11, "R6", "slot1 value", zof(1), 11);
        chk(zof(2) == 16'd18, "R6", "slot2 value", zof(2), 18);
        chk(zof(3) == 16'd33, "R6", "slot3 value", zof(3), 33);
        take(1, "R8"); take(2, "R8"); take(3, "R8");
    endtask

    // Later early-exit op overtakes an earlier main-path op
    task automatic t_out_of_order;
        int seen2 = 0, seen3 = 0;
        put(2, 16'd100, 16'd1, 1);
        put(3, 16'd0, 16'd44, 0);
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            if (n == 1) in_stb = '0;
            if (out_stb[2] && seen2 == 0) seen2 = n;
            if (out_stb[3] && seen3 == 0) seen3 = n;
        end
        chk(seen3 == EARLY_N + 1, "R6", "early slot3 done edge", seen3, EARLY_N + 1);
        chk(seen2 == MAIN_N, "R6", "main slot2 done edge", seen2, MAIN_N);
        chk(zof(2) == 16'd99, "R6", "slot2 value", zof(2), 99);
        chk(zof(3) == 16'd44, "R6", "slot3 value", zof(3), 44);
        take(2, "R8"); take(3, "R8");
    endtask

    // Main op on slot0 and early op on slot1 finish in the same clock
    task automatic t_dual;
        int seen0 = 0, seen1 = 0;
        put(0, 16'd7, 16'd8, 0);
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            if (n == 1) in_stb[0] = 1'b0;
            if (n == 3) put(1, 16'd0, 16'h00AA, 3);
            if (n == 4) in_stb[1] = 1'b0;
            if (out_stb[0] && seen0 == 0) seen0 = n;
            if (out_stb[1] && seen1 == 0) seen1 = n;
        end
        chk(seen0 == MAIN_N, "R7", "main slot0 done edge", seen0, MAIN_N);
        chk(seen1 == MAIN_N, "R7", "early slot1 done same edge", seen1, MAIN_N);
        chk(zof(0) == 16'd15, "R7", "slot0 value", zof(0), 15);
        chk(zof(1) == 16'h00AA, "R7", "slot1 value", zof(1), 16'h00AA);
        take(0, "R8"); take(1, "R8");
    endtask

    // Held result stays put and new operands are refused until ack
    task automatic t_hold;
        logic [DW-1:0] held;
        run_cap: begin
            put(2, 16'd40, 16'd2, 0);
            @(negedge clk);
            chk(in_ack[2] == 1'b0, "R1", "in_ack drops after capture", in_ack[2], 0);
            put(2, 16'd999, 16'd1, 2);
        end
        for (int n = 2; n <= MAIN_N + 4; n++) @(negedge clk);
        held = zof(2);
        chk(out_stb[2] == 1'b1, "R8", "out_stb held", out_stb[2], 1);
        chk(held == 16'd42, "R1", "first capture value kept", held, 42);
        for (int n = 0; n < 5; n++) @(negedge clk);
        chk(out_stb[2] == 1'b1, "R8", "out_stb still held", out_stb[2], 1);
        chk(zof(2) == held, "R8", "out_z stable, stb ignored", zof(2), held);
        in_stb[2] = 1'b0;
        take(2, "R8");
        run_one(2, 16'd6, 16'd3, 2, MAIN_N, "R1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_main_ops();
        t_early();
        t_priority();
        t_out_of_order();
        t_dual();
        t_hold();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule